// File: doc/BRIEF.md
# Dual-Alignment PWM Channel Generator

This block produces one pulse-width-modulated waveform from an 8-bit period value and an 8-bit duty value. A single alignment input selects how the internal counter moves. In edge mode the counter climbs from zero to the period value and restarts. In centred mode it climbs to the period value and then falls back, so each pulse sits symmetrically about the point where the cycle starts. A polarity input sets whether the active part of the cycle is driven high or low.

The counter advances only on cycles where the prescaled tick enable is high. A halt-in-wait control, together with a wait-mode indication, can freeze it. Period and duty writes land in holding registers. These are copied into the working registers at the end of a cycle, or on every clock while the channel is disabled, so a change never cuts a pulse short. Software is expected to change the alignment only while the channel is disabled, and to clear the counter as the last step before enabling.

Top module: `pwm_dual_align`

## Requirements
- R1: After reset, and on the clock after the enable input goes low, the counter output is 0 and the waveform output sits at the inactive level (the inverse of the polarity input).
- R2: With alignment 0 (edge mode), the counter steps 0, 1, …, P and then returns to 0, so one cycle is P+1 counted ticks, where P is the working period.
- R3: In edge mode the output is active while the counter is less than or equal to the working duty D, so D+1 of every P+1 ticks are active.
- R4: With alignment 1 (centred mode), the counter steps up from 0 to P and then down through P−1 to 1 before the cycle restarts at 0, so one cycle is 2P ticks and the counter never exceeds P.
- R5: In centred mode with D < P, the output is active for D ticks at the start and D ticks at the end of each cycle (2D of 2P). A duty of 0 gives a constantly inactive output.
- R6: When D is greater than or equal to P, the output stays active for the whole cycle in either alignment.
- R7: Polarity 1 makes the active level high and polarity 0 makes it low.
- R8: The counter advances only on clocks where the tick enable is 1 and holds otherwise.
- R9: While the halt-in-wait input is 1 and the wait indication is 1, the counter holds. With the halt-in-wait input at 0, the wait indication has no effect.
- R10: A period or duty write goes to a holding register. While the channel is enabled, the new value takes effect at the start of the next cycle. While it is disabled, the value is in use two clocks after the write.
- R11: A counter-clear strobe returns the counter to 0 and to the upward direction on the next clock, which restarts the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Prescaled count enable |
| in_wait | input | 1 | Wait-mode indication |
| ctl_enable | input | 1 | Channel enable |
| ctl_center | input | 1 | Alignment: 0 edge mode, 1 centred mode |
| ctl_polarity | input | 1 | Active level of the output: 1 high, 0 low |
| ctl_halt_wait | input | 1 | Freeze the counter during wait mode |
| per_wr | input | 1 | Period write strobe |
| per_data | input | 8 | Period write data |
| duty_wr | input | 1 | Duty write strobe |
| duty_data | input | 8 | Duty write data |
| cnt_clr | input | 1 | Counter clear strobe |
| pwm_out | output | 1 | PWM waveform |
| cnt_val | output | 8 | Current counter value |

## Verification
On every cycle, the assertions check the following: a disabled channel holds its counter at zero, the counter stays at or below the working period, edge mode steps by one, a missing tick or a halt in wait freezes the counter, the working registers change only on a cycle-end event, and a zero centred duty gives an inactive output. Some properties span a whole cycle, and only the bench scenarios can show them. These are the exact counter sequences and active-tick counts in both alignments and both polarities, the saturation at a large duty, the deferral of a duty change to the next cycle, and the restart after a clear strobe.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;

  typedef enum logic {CNT_UP = 1'b0, CNT_DOWN = 1'b1} cnt_dir_e;

  // Active-phase decision for one counter value.
  function automatic logic chan_active(logic center, cnt_dir_e dir,
                                       int unsigned cnt, int unsigned duty,
                                       int unsigned per);
    if (!center) return cnt <= duty;
    if (duty >= per) return 1'b1;
    return (dir == CNT_DOWN) ? (cnt <= duty) : (cnt < duty);
  endfunction

  // True when the next counted tick starts a new cycle.
  function automatic logic at_boundary(logic center, cnt_dir_e dir,
                                       int unsigned cnt, int unsigned per);
    if (!center) return cnt >= per;
    if (dir == CNT_DOWN) return cnt <= 1;
    return (cnt >= per) && (cnt <= 1);
  endfunction

endpackage

// File: rtl/pwm_dual_shadow.sv
module pwm_dual_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         load,
  input  logic         per_wr,
  input  logic [W-1:0] per_data,
  input  logic         duty_wr,
  input  logic [W-1:0] duty_data,
  output logic [W-1:0] per_act,
  output logic [W-1:0] duty_act
);
  logic [W-1:0] per_buf, duty_buf;
  logic         take;

  assign take = !enable || load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_buf  <= '0;
      duty_buf <= '0;
      per_act  <= '0;
      duty_act <= '0;
    end else begin
      if (per_wr)  per_buf  <= per_data;
      if (duty_wr) duty_buf <= duty_data;
      if (take) begin
        per_act  <= per_buf;
        duty_act <= duty_buf;
      end
    end
  end

  // R10: while running, working values move only on a cycle-end event
  p_hold_between_loads_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !load) |=> ($stable(per_act) && $stable(duty_act)));

endmodule

// File: rtl/pwm_dual_counter.sv
module pwm_dual_counter
  import pwm_dual_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         run,
  input  logic         clr,
  input  logic         center,
  input  logic [W-1:0] per,
  output logic [W-1:0] cnt,
  output cnt_dir_e     dir,
  output logic         cyc_end
);
  logic         boundary;
  logic [W-1:0] cnt_nx;
  cnt_dir_e     dir_nx;

  always_comb begin
    boundary = at_boundary(center, dir, 32'(cnt), 32'(per));
    cnt_nx   = cnt;
    dir_nx   = dir;
    if (boundary) begin
      cnt_nx = '0;
      dir_nx = CNT_UP;
    end else if (!center) begin
      cnt_nx = cnt + W'(1);
      dir_nx = CNT_UP;
    end else if (dir == CNT_UP && cnt < per) begin
      cnt_nx = cnt + W'(1);
    end else begin
      cnt_nx = cnt - W'(1);
      dir_nx = CNT_DOWN;
    end
    cyc_end = run && boundary;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      dir <= CNT_UP;
    end else if (!enable || clr) begin
      cnt <= '0;
      dir <= CNT_UP;
    end else if (run) begin
      cnt <= cnt_nx;
      dir <= dir_nx;
    end
  end

  // R1: a disabled channel parks at zero, counting up
  p_disabled_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt == '0 && dir == CNT_UP));

  // R2: edge mode steps by one below the period
  p_left_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !center && cnt < per) |=> (cnt == $past(cnt) + W'(1)));

  // R4: the counter never passes the working period
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> (cnt <= per));

endmodule

// File: rtl/pwm_dual_wave.sv
module pwm_dual_wave
  import pwm_dual_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         center,
  input  logic         polarity,
  input  cnt_dir_e     dir,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] per,
  input  logic [W-1:0] duty,
  output logic         pwm_out
);
  logic active;

  always_comb begin
    active  = enable && chan_active(center, dir, 32'(cnt), 32'(duty), 32'(per));
    pwm_out = active ? polarity : !polarity;
  end

  // R5: a zero centred duty never shows the active level
  p_center_duty0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && center && duty == '0 && per != '0) |-> (pwm_out == !polarity));

endmodule

// File: rtl/pwm_dual_align.sv
module pwm_dual_align
  import pwm_dual_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         in_wait,
  input  logic         ctl_enable,
  input  logic         ctl_center,
  input  logic         ctl_polarity,
  input  logic         ctl_halt_wait,
  input  logic         per_wr,
  input  logic [W-1:0] per_data,
  input  logic         duty_wr,
  input  logic [W-1:0] duty_data,
  input  logic         cnt_clr,
  output logic         pwm_out,
  output logic [W-1:0] cnt_val
);
  logic         halted;
  logic         run;
  logic         cyc_end;
  logic [W-1:0] per_act, duty_act;
  cnt_dir_e     dir;

  assign halted = ctl_halt_wait && in_wait;
  assign run    = ctl_enable && tick_en && !halted;

  pwm_dual_shadow #(.W(W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .enable(ctl_enable), .load(cyc_end),
    .per_wr(per_wr), .per_data(per_data),
    .duty_wr(duty_wr), .duty_data(duty_data),
    .per_act(per_act), .duty_act(duty_act)
  );

  pwm_dual_counter #(.W(W)) u_counter (
    .clk(clk), .rst_n(rst_n), .enable(ctl_enable), .run(run),
    .clr(cnt_clr), .center(ctl_center), .per(per_act),
    .cnt(cnt_val), .dir(dir), .cyc_end(cyc_end)
  );

  pwm_dual_wave #(.W(W)) u_wave (
    .clk(clk), .rst_n(rst_n), .enable(ctl_enable), .center(ctl_center),
    .polarity(ctl_polarity), .dir(dir), .cnt(cnt_val),
    .per(per_act), .duty(duty_act), .pwm_out(pwm_out)
  );

  // R9: halt in wait freezes an enabled counter
  p_freeze_in_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_enable && halted && !cnt_clr) |=> $stable(cnt_val));

  // R8: no tick, no movement
  p_tick_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_enable && !tick_en && !cnt_clr) |=> $stable(cnt_val));

endmodule

// File: tb/tb_pwm_dual_align.sv
module tb_pwm_dual_align;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1, in_wait = 1'b0;
  logic       ctl_enable = 1'b0, ctl_center = 1'b0, ctl_polarity = 1'b0, ctl_halt_wait = 1'b0;
  logic       per_wr = 1'b0, duty_wr = 1'b0, cnt_clr = 1'b0;
  logic [7:0] per_data = '0, duty_data = '0;
  logic       pwm_out;
  logic [7:0] cnt_val;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {int c; bit o; string tag;} exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;  // 250 MHz

  pwm_dual_align dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .in_wait(in_wait),
    .ctl_enable(ctl_enable), .ctl_center(ctl_center), .ctl_polarity(ctl_polarity),
    .ctl_halt_wait(ctl_halt_wait), .per_wr(per_wr), .per_data(per_data),
    .duty_wr(duty_wr), .duty_data(duty_data), .cnt_clr(cnt_clr),
    .pwm_out(pwm_out), .cnt_val(cnt_val)
  );

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Monitor: pops one expected item per sample point and compares.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (int'(cnt_val) !== e.c || pwm_out !== e.o) begin
          errors++;
          $display("FAIL %s: actual cnt=%0d out=%0b expected cnt=%0d out=%0b",
                   e.tag, cnt_val, pwm_out, e.c, e.o);
        end
      end
    end
  end

  // Driver: configures while disabled, enables, and pushes expectations per clock.
  task automatic run_case(bit c_mode, bit pol_v, int P, int D, int n, int tdiv,
                          int w0, int w1, bit halt_v, int wr_at, int new_d,
                          int clr_at, string tag);
    int cp, dc, dp, len;
    @(negedge clk);
    ctl_enable = 1'b0; ctl_center = c_mode; ctl_polarity = pol_v; ctl_halt_wait = halt_v;
    per_wr = 1'b1; per_data = 8'(P); duty_wr = 1'b1; duty_data = 8'(D);
    @(negedge clk);
    per_wr = 1'b0; duty_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    ctl_enable = 1'b1;
    cp = 0; dc = D; dp = D;
    len = c_mode ? 2 * P : P + 1;
    for (int s = 0; s < n; s++) begin
      int ec;
      bit act;
      ec = (!c_mode || cp <= P) ? cp : 2 * P - cp;
      if (!c_mode) act = (cp <= dc);
      else act = (dc >= P) || (cp < dc) || (cp >= 2 * P - dc);
      sb_q.push_back('{ec, pol_v ? act : !act, tag});
      tick_en = ((s % tdiv) == 0);
      in_wait = (s >= w0 && s < w1);
      duty_wr = (s == wr_at);
      duty_data = 8'(new_d);
      cnt_clr = (s == clr_at);
      if (s == wr_at) dp = new_d;
      if (s == clr_at) cp = 0;
      else if (tick_en && !(halt_v && in_wait)) begin
        if (cp == len - 1) begin cp = 0; dc = dp; end
        else cp++;
      end
      @(negedge clk);
    end
    duty_wr = 1'b0; cnt_clr = 1'b0; tick_en = 1'b1; in_wait = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #9 rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 reset counter", int'(cnt_val), 0);
    chk("R1 R7 reset output inactive", int'(pwm_out), 1);

    run_case(0, 1, 4, 1, 15, 1, -1, -1, 0, -1, 0, -1, "R2 R3 R7 edge pol1");
    run_case(0, 0, 5, 2, 14, 1, -1, -1, 0, -1, 0, -1, "R3 R7 edge pol0");
    run_case(0, 1, 3, 3, 8, 1, -1, -1, 0, -1, 0, -1, "R6 edge duty=per");
    run_case(0, 0, 3, 9, 8, 1, -1, -1, 0, -1, 0, -1, "R6 R7 edge duty>per");
    run_case(1, 1, 4, 2, 20, 1, -1, -1, 0, -1, 0, -1, "R4 R5 centred");
    run_case(1, 1, 6, 5, 14, 1, -1, -1, 0, -1, 0, -1, "R4 R5 centred wide");
    run_case(1, 1, 5, 0, 12, 1, -1, -1, 0, -1, 0, -1, "R5 centred duty0");
    run_case(1, 0, 3, 3, 10, 1, -1, -1, 0, -1, 0, -1, "R6 R7 centred duty=per");
    run_case(0, 1, 3, 1, 16, 2, -1, -1, 0, -1, 0, -1, "R8 tick gating");
    run_case(0, 1, 4, 2, 20, 1, 5, 10, 1, -1, 0, -1, "R9 halt in wait");
    run_case(1, 1, 4, 1, 16, 1, 5, 10, 0, -1, 0, -1, "R9 wait without halt");
    run_case(0, 1, 4, 1, 20, 1, -1, -1, 0, 6, 3, -1, "R10 buffered duty");
    run_case(0, 1, 5, 2, 16, 1, -1, -1, 0, -1, 0, 3, "R11 clear edge");
    run_case(1, 1, 4, 2, 16, 1, -1, -1, 0, -1, 0, 6, "R11 clear centred");

    ctl_enable = 1'b0;
    @(negedge clk);
    #1;
    chk("R1 disabled counter", int'(cnt_val), 0);
    chk("R1 disabled output inactive", int'(pwm_out), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule